// File: doc/BRIEF.md
# Nibble Mode Reverse Receiver

This block lets a host pull bytes back from a peripheral over a parallel printer port that runs in the four-bit reverse mode. The port's data lines are not used. Each byte comes over four status lines as two 4-bit halves. For each half the host lowers its request line, the peripheral answers by pulling its acknowledge line low, and the host takes the status lines and raises the request again. The next half is requested only after the acknowledge line has gone high again. Another block has already placed the peripheral in this mode before a transfer starts.

Software or a sequencer gives a byte count and a one-cycle start pulse. The receiver collects that many bytes and offers each one on a valid/ready stream. A running count of delivered bytes is shown next to the stream. If the peripheral is silent for too long, the receiver stops and raises a sticky timeout flag. The wait for the first half of a byte is allowed a long idle window. Every later wait uses a shorter response window. All peripheral inputs pass through a synchronizer of `SYNC_STAGES` flops before the control logic uses them.

Top module: `nibble_rev_rx`

## Requirements
- R1: During and right after reset, `hostReqN` is 1, `rxValid` is 0, `busy` is 0, `timeoutErr` is 0 and `rxCount` is 0. `hostSelN` and `hostStrobeN` are 1 at all times.
- R2: A `start` pulse taken while idle clears `rxCount` and `timeoutErr`. If `xferLen` is nonzero, `busy` goes to 1 and `hostReqN` drops to 0 on the following clock. If `xferLen` is zero, the block stays idle with `hostReqN` at 1. A `start` that arrives while `busy` is 1 is ignored.
- R3: Once the synchronized `periphAckN` is seen low while a request is pending, `hostReqN` returns to 1. A new request is made only after the synchronized `periphAckN` is seen high again. `hostReqN` is low only while `busy` is 1.
- R4: The first half of each byte fills `rxData[3:0]` as follows: bit 0 is the level of `periphFaultN`, bit 1 is `periphSelect`, bit 2 is `periphPaperEnd`, and bit 3 is the inverse of the `periphBusy` pin.
- R5: The second half fills `rxData[7:4]` with the same line-to-bit order as the first half. Bit 7 is the inverse of `periphBusy`.
- R6: `rxValid` rises only after both halves have been taken and the acknowledge line has been released. While `rxReady` is 0, `rxData` and `rxValid` stay unchanged and no new request is made (`hostReqN` stays 1).
- R7: Each cycle with `rxValid` and `rxReady` both high adds exactly one to `rxCount`; at no other time does it change, except when a start clears it. After `xferLen` bytes have been delivered, `busy` returns to 0.
- R8: The wait for the first half of a byte times out after `IDLE_TO` cycles with `hostReqN` low. A wait shorter than that completes normally.
- R9: The wait for the second half, and every wait for the acknowledge line to return high, times out after `RESP_TO` cycles. On any timeout, `timeoutErr` rises, `busy` drops and `hostReqN` goes to 1 on the same clock. The flag stays set until the next start.
- R10: A change on the peripheral inputs reaches the control logic after `SYNC_STAGES` clocks. With the default of 2, `hostReqN` rises on the third clock edge after `periphAckN` falls during a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts a transfer |
| xferLen | input | LEN_W | Number of bytes to receive |
| hostReqN | output | 1 | Host request/acknowledge line, low to ask for a half-byte |
| hostSelN | output | 1 | Peripheral select line, held high |
| hostStrobeN | output | 1 | Host strobe line, held high |
| periphAckN | input | 1 | Peripheral acknowledge, low marks a half-byte as valid |
| periphFaultN | input | 1 | Status line, data bits 0 and 4 |
| periphSelect | input | 1 | Status line, data bits 1 and 5 |
| periphPaperEnd | input | 1 | Status line, data bits 2 and 6 |
| periphBusy | input | 1 | Status line, inverted into data bits 3 and 7 |
| rxData | output | 8 | Assembled byte |
| rxValid | output | 1 | Byte available |
| rxReady | input | 1 | Consumer accepts the byte |
| rxCount | output | LEN_W | Bytes delivered since the last start |
| busy | output | 1 | Transfer in progress |
| timeoutErr | output | 1 | Sticky timeout flag |

## Verification
Every output comes from a register. A start shows up on `busy` and `hostReqN` one clock after it is sampled. An acknowledge edge on a pin moves `hostReqN` three clocks later: two clocks in the synchronizer and one in the state register. A handshake on the output stream updates `rxCount` and `rxValid` one clock later. A timeout appears exactly `IDLE_TO` or `RESP_TO` clocks after the wait it ends. The bench drives its inputs on the falling edge. It advances a behavioural model, whose synchronizer delay is held in a queue, on each rising edge, and compares all outputs on the next falling edge. Directed counts of clocks check the acknowledge latency and both timeout windows against those numbers.

// File: rtl/nibble_rx_pkg.sv
package nibble_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_RELEASE = 2'd2,
    ST_EMIT    = 2'd3
  } rxState_t;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic capLo;
    logic capHi;
    logic clrCount;
    logic incCount;
  } dpStrobe_t;

  // synchronized line bundle: {ack, busyLogical, paperEnd, select, faultN}
  localparam int LINE_W = 5;
  localparam int ACK_BIT = 4;
  localparam logic [LINE_W-1:0] LINES_AT_REST = 5'b10000;
endpackage

// File: rtl/nibble_rx_dpath.sv
module nibble_rx_dpath
  import nibble_rx_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periphAckN,
  input  logic             periphFaultN,
  input  logic             periphSelect,
  input  logic             periphPaperEnd,
  input  logic             periphBusy,
  input  dpStrobe_t        strobe,
  output logic             ackSyncN,
  output logic [7:0]       byteData,
  output logic [LEN_W-1:0] byteCount
);
  localparam int NIB_W = LINE_W - 1;

  logic [LINE_W-1:0] rawLines;
  logic [SYNC_STAGES-1:0][LINE_W-1:0] syncPipe;
  logic [LINE_W-1:0] syncLines;
  logic [NIB_W-1:0] nibLo, nibHi;

  // R4 R5: fixed line order, busy pin inverted to its logical value
  assign rawLines = {periphAckN, ~periphBusy, periphPaperEnd, periphSelect, periphFaultN};

  // R10: synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= {SYNC_STAGES{LINES_AT_REST}};
    end else begin
      syncPipe[0] <= rawLines;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign syncLines = syncPipe[SYNC_STAGES-1];
  assign ackSyncN  = syncLines[ACK_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibLo <= '0;
      nibHi <= '0;
    end else begin
      if (strobe.capLo) nibLo <= syncLines[NIB_W-1:0];
      if (strobe.capHi) nibHi <= syncLines[NIB_W-1:0];
    end
  end

  assign byteData = {nibHi, nibLo};

  // R7: delivered-byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                byteCount <= '0;
    else if (strobe.clrCount) byteCount <= '0;
    else if (strobe.incCount) byteCount <= byteCount + 1'b1;
  end
endmodule

// File: rtl/nibble_rx_ctrl.sv
module nibble_rx_ctrl
  import nibble_rx_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int IDLE_TO = 100,
  parameter int RESP_TO = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] xferLen,
  input  logic             ackSyncN,
  input  logic             byteReady,
  output dpStrobe_t        strobe,
  output logic             hostReqN,
  output logic             byteValid,
  output logic             busy,
  output logic             timeoutErr
);
  localparam int MAX_TO = (IDLE_TO > RESP_TO) ? IDLE_TO : RESP_TO;
  localparam int TMR_W  = $clog2(MAX_TO) + 1;
  localparam logic [TMR_W-1:0] IDLE_LAST = TMR_W'(IDLE_TO - 1);
  localparam logic [TMR_W-1:0] RESP_LAST = TMR_W'(RESP_TO - 1);

  rxState_t state, stateNxt;
  logic [TMR_W-1:0] timer, timerNxt;
  logic [LEN_W-1:0] remaining, remainingNxt;
  logic nibHi, nibHiNxt;
  logic errFlag, errFlagNxt;
  logic [TMR_W-1:0] reqLast;

  // R8 R9: first half waits the idle window, second half the response window
  assign reqLast = nibHi ? RESP_LAST : IDLE_LAST;

  always_comb begin
    stateNxt     = state;
    timerNxt     = timer;
    remainingNxt = remaining;
    nibHiNxt     = nibHi;
    errFlagNxt   = errFlag;
    strobe       = '0;
    unique case (state)
      ST_IDLE: begin
        // R2
        if (start) begin
          errFlagNxt      = 1'b0;
          strobe.clrCount = 1'b1;
          remainingNxt    = xferLen;
          nibHiNxt        = 1'b0;
          timerNxt        = '0;
          if (xferLen != '0) stateNxt = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!ackSyncN) begin
          strobe.capLo = !nibHi;
          strobe.capHi = nibHi;
          timerNxt     = '0;
          stateNxt     = ST_RELEASE;
        end else if (timer == reqLast) begin
          errFlagNxt = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          timerNxt = timer + 1'b1;
        end
      end
      ST_RELEASE: begin
        // R3: wait for the acknowledge line to return high
        if (ackSyncN) begin
          timerNxt = '0;
          if (!nibHi) begin
            nibHiNxt = 1'b1;
            stateNxt = ST_REQ;
          end else begin
            stateNxt = ST_EMIT;
          end
        end else if (timer == RESP_LAST) begin
          errFlagNxt = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          timerNxt = timer + 1'b1;
        end
      end
      ST_EMIT: begin
        // R6 R7
        if (byteReady) begin
          strobe.incCount = 1'b1;
          remainingNxt    = remaining - 1'b1;
          nibHiNxt        = 1'b0;
          timerNxt        = '0;
          stateNxt        = (remaining == LEN_W'(1)) ? ST_IDLE : ST_REQ;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      remaining <= '0;
      nibHi     <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      state     <= stateNxt;
      timer     <= timerNxt;
      remaining <= remainingNxt;
      nibHi     <= nibHiNxt;
      errFlag   <= errFlagNxt;
    end
  end

  assign hostReqN   = (state != ST_REQ);
  assign byteValid  = (state == ST_EMIT);
  assign busy       = (state != ST_IDLE);
  assign timeoutErr = errFlag;
endmodule

// File: rtl/nibble_rev_rx.sv
module nibble_rev_rx
  import nibble_rx_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int IDLE_TO     = 100,
  parameter int RESP_TO     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] xferLen,
  output logic             hostReqN,
  output logic             hostSelN,
  output logic             hostStrobeN,
  input  logic             periphAckN,
  input  logic             periphFaultN,
  input  logic             periphSelect,
  input  logic             periphPaperEnd,
  input  logic             periphBusy,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic [LEN_W-1:0] rxCount,
  output logic             busy,
  output logic             timeoutErr
);
  dpStrobe_t strobe;
  logic ackSyncN;

  // R1: these two lines stay high in this mode
  assign hostSelN    = 1'b1;
  assign hostStrobeN = 1'b1;

  nibble_rx_ctrl #(
    .LEN_W(LEN_W), .IDLE_TO(IDLE_TO), .RESP_TO(RESP_TO)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen),
    .ackSyncN(ackSyncN), .byteReady(rxReady), .strobe(strobe),
    .hostReqN(hostReqN), .byteValid(rxValid), .busy(busy),
    .timeoutErr(timeoutErr)
  );

  nibble_rx_dpath #(
    .LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .periphAckN(periphAckN),
    .periphFaultN(periphFaultN), .periphSelect(periphSelect),
    .periphPaperEnd(periphPaperEnd), .periphBusy(periphBusy),
    .strobe(strobe), .ackSyncN(ackSyncN), .byteData(rxData),
    .byteCount(rxCount)
  );
endmodule

// File: rtl/nibble_rev_rx_chk.sv
module nibble_rev_rx_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             hostReqN,
  input logic [7:0]       rxData,
  input logic             rxValid,
  input logic             rxReady,
  input logic [LEN_W-1:0] rxCount,
  input logic             busy,
  input logic             timeoutErr
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R6
  no_req_while_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> hostReqN);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> (rxCount == LEN_W'($past(rxCount) + 1)));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(rxValid && rxReady) && !(start && !busy)) |=> $stable(rxCount));

  // R9
  err_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (!busy && hostReqN));

  // R3
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostReqN |-> busy);
endmodule

bind nibble_rev_rx nibble_rev_rx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .hostReqN(hostReqN),
  .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
  .rxCount(rxCount), .busy(busy), .timeoutErr(timeoutErr)
);

// File: tb/nibble_rev_rx_test.sv
`timescale 1ns/1ps
module nibble_rev_rx_test;
  localparam int LEN_W = 8;
  localparam int IDLE_TO = 100;
  localparam int RESP_TO = 20;
  localparam int SYNC = 2;

  logic clk = 0, rstN = 0, start = 0;
  logic [LEN_W-1:0] xferLen = '0;
  logic hostReqN, hostSelN, hostStrobeN;
  logic periphAckN = 1, periphFaultN = 0, periphSelect = 0, periphPaperEnd = 0, periphBusy = 1;
  logic [7:0] rxData;
  logic rxValid, rxReady;
  logic [LEN_W-1:0] rxCount;
  logic busy, timeoutErr;

  int nChecks = 0, nFails = 0;
  bit stallMode = 0;
  bit finished = 0;
  int cyc = 0;
  logic [7:0] got[$];
  logic [7:0] want[$];

  always #2 clk = ~clk;

  nibble_rev_rx #(.LEN_W(LEN_W), .IDLE_TO(IDLE_TO), .RESP_TO(RESP_TO), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .xferLen(xferLen),
    .hostReqN(hostReqN), .hostSelN(hostSelN), .hostStrobeN(hostStrobeN),
    .periphAckN(periphAckN), .periphFaultN(periphFaultN), .periphSelect(periphSelect),
    .periphPaperEnd(periphPaperEnd), .periphBusy(periphBusy),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .rxCount(rxCount),
    .busy(busy), .timeoutErr(timeoutErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int mState = 0, mTimer = 0, mRem = 0, mNib = 0, mCount = 0;
  bit mErr = 0;
  logic [3:0] mLo = 0, mHi = 0;
  logic [4:0] syncQ[$];
  logic [4:0] vis;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mTimer = 0; mRem = 0; mNib = 0; mCount = 0; mErr = 0; mLo = 0; mHi = 0;
      syncQ.delete();
      for (int i = 0; i < SYNC; i++) syncQ.push_back(5'b10000);
    end else begin
      cyc++;
      if (rxValid && rxReady) got.push_back(rxData);
      vis = syncQ.pop_front();
      syncQ.push_back({periphAckN, ~periphBusy, periphPaperEnd, periphSelect, periphFaultN});
      case (mState)
        0: if (start) begin
             mErr = 0; mCount = 0; mRem = xferLen; mNib = 0; mTimer = 0;
             mState = (xferLen != 0) ? 1 : 0;
           end
        1: if (!vis[4]) begin
             if (mNib == 0) mLo = vis[3:0]; else mHi = vis[3:0];
             mTimer = 0; mState = 2;
           end else if (mTimer == ((mNib != 0) ? RESP_TO : IDLE_TO) - 1) begin
             mErr = 1; mState = 0;
           end else mTimer++;
        2: if (vis[4]) begin
             mTimer = 0;
             if (mNib == 0) begin mNib = 1; mState = 1; end else mState = 3;
           end else if (mTimer == RESP_TO - 1) begin
             mErr = 1; mState = 0;
           end else mTimer++;
        default: if (rxReady) begin
             mCount++; mRem--; mNib = 0; mTimer = 0;
             mState = (mRem == 0) ? 0 : 1;
           end
      endcase
    end
  end

  // ready pattern and per-cycle comparison on the falling edge
  always @(negedge clk) begin
    rxReady = stallMode ? (cyc % 4 == 3) : 1'b1;
    if (rstN && !finished) begin
      check(hostReqN == (mState != 1), "R3 hostReqN", hostReqN, mState != 1);
      check(rxValid == (mState == 3), "R6 rxValid", rxValid, mState == 3);
      check(busy == (mState != 0), "R2 busy", busy, mState != 0);
      check(timeoutErr == mErr, "R9 timeoutErr", timeoutErr, mErr);
      check(rxCount == LEN_W'(mCount), "R7 rxCount", rxCount, mCount);
      if (mState == 3) check(rxData == {mHi, mLo}, "R4 R5 rxData", rxData, {mHi, mLo});
      check(hostSelN && hostStrobeN, "R1 held lines", {hostSelN, hostStrobeN}, 3);
    end
  end

  task automatic pulseStart(input int len);
    @(negedge clk);
    start = 1; xferLen = LEN_W'(len);
    @(negedge clk);
    start = 0;
  endtask

  // peripheral side: answer one half-byte
  task automatic sendNib(input logic [3:0] n, input int lat, input int hold);
    int c;
    while (hostReqN !== 1'b0) @(negedge clk);
    repeat (lat) @(negedge clk);
    periphFaultN = n[0]; periphSelect = n[1]; periphPaperEnd = n[2]; periphBusy = ~n[3];
    periphAckN = 0;
    c = 0;
    while (hostReqN !== 1'b1) begin @(negedge clk); c++; end
    check(c == SYNC + 1, "R10 ack latency", c, SYNC + 1);
    repeat (hold) @(negedge clk);
    periphAckN = 1;
  endtask

  task automatic sendByte(input logic [7:0] b, input int lat1, input int lat2, input int hold);
    want.push_back(b);
    sendNib(b[3:0], lat1, hold);
    sendNib(b[7:4], lat2, hold);
  endtask

  task automatic waitIdle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic compareBytes(input string tag);
    check(got.size() == want.size(), tag, got.size(), want.size());
    for (int i = 0; i < want.size() && i < got.size(); i++)
      check(got[i] == want[i], tag, got[i], want[i]);
    got.delete(); want.delete();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hostReqN == 1 && rxValid == 0 && busy == 0, "R1 reset outputs", {hostReqN, rxValid, busy}, 4);
    check(timeoutErr == 0 && rxCount == 0, "R1 reset flags", {timeoutErr, rxCount}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(hostReqN == 1 && busy == 0, "R1 after reset", {hostReqN, busy}, 2);

    // three bytes, fast peripheral; a start while busy is ignored (R2)
    fork
      begin
        pulseStart(3);
        sendByte(8'hA5, 0, 1, 0);
        sendByte(8'h3C, 2, 0, 1);
        sendByte(8'hF0, 1, 1, 2);
      end
      begin
        repeat (20) @(negedge clk);
        start = 1; xferLen = 8'd9;
        @(negedge clk);
        start = 0;
      end
    join
    waitIdle();
    check(rxCount == 3, "R7 count after three", rxCount, 3);
    check(busy == 0, "R2 start while busy ignored", busy, 0);
    compareBytes("R4 R5 bytes run one");

    // four bytes with consumer stalls; one first half waits 50 cycles (R8)
    stallMode = 1;
    pulseStart(4);
    sendByte(8'h00, 0, 0, 0);
    sendByte(8'hFF, 50, 3, 1);
    sendByte(8'h69, 4, 7, 0);
    sendByte(8'h96, 1, 2, 3);
    waitIdle();
    stallMode = 0;
    check(timeoutErr == 0, "R8 long first wait accepted", timeoutErr, 0);
    check(rxCount == 4, "R7 count after four", rxCount, 4);
    compareBytes("R4 R5 bytes run two");

    // zero length start (R2)
    pulseStart(0);
    repeat (10) @(negedge clk);
    check(busy == 0 && hostReqN == 1, "R2 zero length stays idle", {busy, hostReqN}, 1);
    check(rxCount == 0, "R2 zero length clears count", rxCount, 0);

    // first half never answered (R8)
    pulseStart(1);
    while (hostReqN !== 1'b0) @(negedge clk);
    n = 0;
    while (!timeoutErr && n < 1000) begin @(negedge clk); n++; end
    check(n == IDLE_TO, "R8 first half timeout", n, IDLE_TO);
    check(busy == 0 && hostReqN == 1, "R9 idle after timeout", {busy, hostReqN}, 1);

    // second half never answered (R9)
    pulseStart(1);
    check(timeoutErr == 0, "R9 start clears error", timeoutErr, 1'b0);
    sendNib(4'h7, 0, 0);
    while (hostReqN !== 1'b0) @(negedge clk);
    n = 0;
    while (!timeoutErr && n < 1000) begin @(negedge clk); n++; end
    check(n == RESP_TO, "R9 second half timeout", n, RESP_TO);

    // acknowledge never released (R9)
    pulseStart(1);
    while (hostReqN !== 1'b0) @(negedge clk);
    periphAckN = 0;
    while (hostReqN !== 1'b1) @(negedge clk);
    n = 0;
    while (!timeoutErr && n < 1000) begin @(negedge clk); n++; end
    check(n == RESP_TO, "R9 release timeout", n, RESP_TO);
    periphAckN = 1;
    repeat (4) @(negedge clk);

    // recovery: one byte after an error
    pulseStart(1);
    sendByte(8'h5A, 0, 0, 0);
    waitIdle();
    check(timeoutErr == 0 && rxCount == 1, "R7 recovery byte", {timeoutErr, rxCount}, 1);
    compareBytes("R4 R5 recovery byte");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule